// File: doc/BRIEF.md
# Dual-Channel Potentiometer Serial Controller

This block is the digital front end of a two-channel digitally controlled resistor. It sits on a two-wire I2C-compatible bus as a slave. It holds one 8-bit wiper code per channel, two general-purpose logic output latches and a shutdown register bit. The two bus lines arrive asynchronously and are oversampled by the system clock. The block drives SDA only through an open-drain enable: when the enable is high, the pad pulls the line low.

A write transfer has three parts. The first is the address byte. The second is one instruction byte, which chooses a channel and sets the control bits. After that come any number of data bytes, and each one loads the chosen channel. A read transfer has no instruction byte. It returns the code of the channel that the most recent write chose. The analog side reads the wiper codes and the effective shutdown flag straight from the ports. That flag is the OR of the register bit and the active-low shutdown pin.

The bus is the only data path. The block never holds SCL low, so it applies no back-pressure. The master sets the pace of every byte, and the slave keeps up with any SCL period of at least six system clocks per phase.

Top module: `dualpot_i2c_ctrl`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 01011 followed by `addr_strap_i[1]` and `addr_strap_i[0]`. On a mismatch it gives no acknowledge and ignores every byte until the next START.
- R2: In the instruction byte, bit 7 selects the channel, bit 6 requests a midscale reset, bit 5 is the shutdown bit, bit 4 drives `out2_o`, bit 3 drives `out1_o`, and bits 2 to 0 are ignored. The two outputs and the shutdown bit take the new values once the instruction byte is received.
- R3: Each data byte in a write is acknowledged and replaces the code of the selected channel. Bit 7 = 0 of the instruction selects channel 1, and bit 7 = 1 selects channel 2. The other channel is unchanged.
- R4: Within one write transfer, every further data byte updates the same channel under the same instruction.
- R5: A midscale reset sets the selected channel to 0x80. Any data bytes that follow in the same transfer are acknowledged but do not change the code.
- R6: `shutdown_o` is high when `shdn_n_i` is low or the shutdown bit is set. Entering or leaving shutdown leaves both wiper codes unchanged.
- R7: After reset, both wiper codes are 0x80, both logic outputs are 0, and `shutdown_o` is 0 while `shdn_n_i` is high.
- R8: When the read/write bit (bit 0 of the address byte) is 1, the block sends the selected channel's code MSB first, starting right after the address acknowledge. A master no-acknowledge ends the transfer. The same code can be read again in later transfers.
- R9: A repeated START, even in the middle of a byte, abandons the current transfer and begins a new address decode.
- R10: The SDA drive enable changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; also the power-on preset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_oe_o | output | 1 | High to pull SDA low |
| addr_strap_i | input | 2 | Two low address bits taken from board straps |
| shdn_n_i | input | 1 | Active-low shutdown pin |
| wiper1_o | output | 8 | Channel 1 wiper code |
| wiper2_o | output | 8 | Channel 2 wiper code |
| shutdown_o | output | 1 | Effective shutdown flag |
| out1_o | output | 1 | Logic output latch 1 |
| out2_o | output | 1 | Logic output latch 2 |

## Verification
Two sources can change the effective shutdown state at the same moment: the external pin and the shutdown bit that an instruction byte writes. The bench holds the pin low while a write clears the register bit, and it checks that `shutdown_o` stays high. It then releases the pin and checks that the flag drops and that both wiper codes are intact. A second pairing is the midscale reset arriving in the same transfer as data bytes. The bench checks that those bytes are acknowledged and that the selected code still reads back as 0x80.

// File: rtl/dualpot_pkg.sv
package dualpot_pkg;
  localparam int          BYTE_W     = 8;
  localparam int          NUM_CH     = 2;
  localparam int          STRAP_W    = 2;
  localparam logic [4:0]  DEV_PREFIX = 5'b01011;
  localparam logic [7:0]  MID_CODE   = 8'h80;
  localparam int          BIT_CNT_W  = $clog2(BYTE_W + 1);

  // instruction byte field positions (decoded by the register bank)
  localparam int IB_SEL = 7;
  localparam int IB_MID = 6;
  localparam int IB_SD  = 5;
  localparam int IB_O2  = 4;
  localparam int IB_O1  = 3;

  typedef enum logic [2:0] {
    LK_IDLE, LK_RX, LK_ACK, LK_TX, LK_RACK
  } link_st_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INSTR, PH_DATA
  } phase_t;
endpackage

// File: rtl/pot_bus_sampler.sv
module pot_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o    = scl_sh[STAGES-1];
  assign sda_o    = sda_sh[STAGES-1];
  assign scl_rise = scl_o & ~scl_p;
  assign scl_fall = ~scl_o & scl_p;
  assign start_o  = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o   = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/pot_link_fsm.sv
module pot_link_fsm
  import dualpot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl,
  input  logic               sda,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_oe,
  output logic               instr_stb,
  output logic               data_stb,
  output logic [BYTE_W-1:0]  rx_byte
);
  link_st_t             st;
  phase_t               ph;
  logic [BIT_CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0]    shreg, txreg;
  logic                 rnw, mack;
  logic                 addr_hit;

  assign addr_hit = (shreg[BYTE_W-1:1] == {DEV_PREFIX, strap});
  assign rx_byte  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LK_IDLE;
      ph        <= PH_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      rnw       <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      instr_stb <= 1'b0;
      data_stb  <= 1'b0;
    end else begin
      instr_stb <= 1'b0;
      data_stb  <= 1'b0;
      if (start_det) begin
        st     <= LK_RX;
        ph     <= PH_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= LK_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_RX: begin
            if (scl_rise && bitcnt != BIT_CNT_W'(BYTE_W)) begin
              shreg  <= {shreg[BYTE_W-2:0], sda};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BIT_CNT_W'(BYTE_W)) begin
              case (ph)
                PH_ADDR: begin
                  if (addr_hit) begin
                    sda_oe <= 1'b1;
                    rnw    <= shreg[0];
                    st     <= LK_ACK;
                  end else begin
                    st <= LK_IDLE;
                  end
                end
                PH_INSTR: begin
                  sda_oe    <= 1'b1;
                  instr_stb <= 1'b1;
                  st        <= LK_ACK;
                end
                default: begin
                  sda_oe   <= 1'b1;
                  data_stb <= 1'b1;
                  st       <= LK_ACK;
                end
              endcase
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (ph == PH_ADDR && rnw) begin
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                st     <= LK_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= LK_RX;
                ph     <= (ph == PH_ADDR) ? PH_INSTR : PH_DATA;
              end
            end
          end
          LK_TX: begin
            if (scl_fall) begin
              if (bitcnt == BIT_CNT_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                st     <= LK_RACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          LK_RACK: begin
            if (scl_rise) begin
              mack <= ~sda;
            end else if (scl_fall) begin
              if (mack) begin
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                st     <= LK_TX;
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: an acknowledge of the address phase implies the received address matched
  assert_ack_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_ACK && ph == PH_ADDR) |-> (shreg[BYTE_W-1:1] == {DEV_PREFIX, strap}));

  // R10: drive enable moves only while sampled SCL is low
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !start_det && !stop_det) |-> !scl);
endmodule

// File: rtl/pot_reg_bank.sv
module pot_reg_bank
  import dualpot_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           instr_stb,
  input  logic                           data_stb,
  input  logic [BYTE_W-1:0]              rx_byte,
  output logic [NUM_CH-1:0][BYTE_W-1:0]  wiper_q,
  output logic [BYTE_W-1:0]              rd_byte,
  output logic                           sd_q,
  output logic                           o1_q,
  output logic                           o2_q
);
  logic sel_q;
  logic mid_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      mid_lock <= 1'b0;
      sd_q     <= 1'b0;
      o1_q     <= 1'b0;
      o2_q     <= 1'b0;
    end else if (instr_stb) begin
      sel_q    <= rx_byte[IB_SEL];
      mid_lock <= rx_byte[IB_MID];
      sd_q     <= rx_byte[IB_SD];
      o2_q     <= rx_byte[IB_O2];
      o1_q     <= rx_byte[IB_O1];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_q[ch] <= MID_CODE;
      end else if (instr_stb && rx_byte[IB_SEL] == 1'(ch) && rx_byte[IB_MID]) begin
        wiper_q[ch] <= MID_CODE;
      end else if (data_stb && sel_q == 1'(ch) && !mid_lock) begin
        wiper_q[ch] <= rx_byte;
      end
    end

    // R5: midscale request lands the selected channel on the center code
    assert_midscale_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_stb && rx_byte[IB_SEL] == 1'(ch) && rx_byte[IB_MID]) |=> (wiper_q[ch] == MID_CODE));

    // R6: without a bus strobe the code is held (shutdown has no path here)
    assert_wiper_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_stb && !data_stb) |=> $stable(wiper_q[ch]));

    // R3: an accepted data byte becomes the selected channel code
    assert_data_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_stb && sel_q == 1'(ch) && !mid_lock) |=> (wiper_q[ch] == $past(rx_byte)));
  end

  assign rd_byte = wiper_q[sel_q];
endmodule

// File: rtl/dualpot_i2c_ctrl.sv
module dualpot_i2c_ctrl
  import dualpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] addr_strap_i,
  input  logic               shdn_n_i,
  output logic [BYTE_W-1:0]  wiper1_o,
  output logic [BYTE_W-1:0]  wiper2_o,
  output logic               shutdown_o,
  output logic               out1_o,
  output logic               out2_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic instr_stb, data_stb, sd_q;
  logic [BYTE_W-1:0] rx_byte, rd_byte;
  logic [NUM_CH-1:0][BYTE_W-1:0] wiper_q;

  pot_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  pot_link_fsm u_link (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap_i), .rd_byte(rd_byte),
    .sda_oe(sda_oe_o), .instr_stb(instr_stb), .data_stb(data_stb),
    .rx_byte(rx_byte)
  );

  pot_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .instr_stb(instr_stb), .data_stb(data_stb),
    .rx_byte(rx_byte), .wiper_q(wiper_q), .rd_byte(rd_byte),
    .sd_q(sd_q), .o1_q(out1_o), .o2_q(out2_o)
  );

  assign wiper1_o   = wiper_q[0];
  assign wiper2_o   = wiper_q[1];
  assign shutdown_o = sd_q | ~shdn_n_i;
endmodule

// File: tb/dualpot_i2c_ctrl_test.sv
module dualpot_i2c_ctrl_test;
  localparam int Q = 6;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [6:0] DEV   = {5'b01011, STRAP};

  // {instr, data, exp_w1, exp_w2, flags {5'b0, o1, o2, sd}}
  localparam logic [39:0] VEC [6] = '{
    {8'h00, 8'h3C, 8'h3C, 8'h80, 8'b000},
    {8'h88, 8'hF0, 8'h3C, 8'hF0, 8'b100},
    {8'h10, 8'h00, 8'h00, 8'hF0, 8'b010},
    {8'hA0, 8'h55, 8'h00, 8'h55, 8'b001},
    {8'h40, 8'hEE, 8'h80, 8'h55, 8'b000},
    {8'hD8, 8'h01, 8'h80, 8'h80, 8'b110}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic shdn_n = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [7:0] w1, w2;
  logic sd_o, o1, o2;
  int checks = 0;
  int fails = 0;
  int viol = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  dualpot_i2c_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_strap_i(STRAP), .shdn_n_i(shdn_n), .wiper1_o(w1), .wiper2_o(w2),
    .shutdown_o(sd_o), .out1_o(o1), .out2_o(o2)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b0; hold();
    scl = 1'b0;   hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl = 1'b1;   hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl = 1'b1;   hold();
      scl = 1'b0;
    end
    sda_m = 1'b1; hold();
    scl = 1'b1;   hold();
    ack = ~sda_line;
    scl = 1'b0;   hold();
  endtask

  task automatic get_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hold();
      scl = 1'b1; hold();
      b = {b[6:0], sda_line};
      scl = 1'b0;
    end
    hold();
    sda_m = ~master_ack; hold();
    scl = 1'b1; hold();
    scl = 1'b0; hold();
    sda_m = 1'b1;
  endtask

  task automatic read_code(input string req, input logic [7:0] exp);
    logic a;
    logic [7:0] b;
    bus_start();
    put_byte({DEV, 1'b1}, a);
    chk(req, "read address ack", a, 1'b1);
    get_byte(1'b0, b);
    chk(req, "read data", b, exp);
    bus_stop();
  endtask

  // R10 monitor: drive enable must not move while the bench holds SCL high
  always @(negedge clk) begin : mon
    logic prev_oe;
    if (rst_n && scl && sda_oe !== prev_oe) viol++;
    prev_oe = sda_oe;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 reset state
    chk("R7", "wiper1 reset", w1, 8'h80);
    chk("R7", "wiper2 reset", w2, 8'h80);
    chk("R7", "out1 reset", o1, 1'b0);
    chk("R7", "out2 reset", o2, 1'b0);
    chk("R7", "shutdown reset", sd_o, 1'b0);
    chk("R7", "sda released", sda_oe, 1'b0);

    // table walk: R2 R3 R5 R8
    foreach (VEC[k]) begin
      logic [7:0] ins, dat, e1, e2, fl;
      {ins, dat, e1, e2, fl} = VEC[k];
      bus_start();
      put_byte({DEV, 1'b0}, a); chk("R1", "address ack", a, 1'b1);
      put_byte(ins, a);         chk("R2", "instruction ack", a, 1'b1);
      put_byte(dat, a);         chk("R3", "data ack", a, 1'b1);
      bus_stop();
      chk("R3", "wiper1", w1, e1);
      chk("R3", "wiper2", w2, e2);
      chk("R2", "out1", o1, fl[2]);
      chk("R2", "out2", o2, fl[1]);
      chk("R6", "shutdown flag", sd_o, fl[0]);
      read_code("R8", ins[7] ? e2 : e1);
    end
    // R8 repeated read of the same channel (channel 2 = 0x80)
    read_code("R8", 8'h80);

    // R1 wrong strap: no ack, following bytes ignored
    bus_start();
    put_byte({5'b01011, 2'b01, 1'b0}, a); chk("R1", "mismatch no ack", a, 1'b0);
    put_byte(8'h00, a);                   chk("R1", "ignored byte no ack", a, 1'b0);
    put_byte(8'h11, a);
    bus_stop();
    chk("R1", "wiper1 untouched", w1, 8'h80);

    // R4 several data bytes in one transfer
    bus_start();
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h00, a);
    put_byte(8'h10, a); chk("R4", "first data ack", a, 1'b1);
    chk("R4", "wiper1 after first", w1, 8'h10);
    put_byte(8'h20, a); chk("R4", "second data ack", a, 1'b1);
    chk("R4", "wiper1 after second", w1, 8'h20);
    bus_stop();
    chk("R4", "wiper2 untouched", w2, 8'h80);

    // R5 midscale followed by data bytes that are acked but dropped
    bus_start();
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h40, a);
    put_byte(8'h12, a); chk("R5", "data after midscale ack", a, 1'b1);
    put_byte(8'h34, a); chk("R5", "second data after midscale ack", a, 1'b1);
    bus_stop();
    chk("R5", "wiper1 stays mid", w1, 8'h80);

    // R9 repeated START in the middle of a data byte
    bus_start();
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h80, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; hold(); scl = 1'b1; hold(); scl = 1'b0;
    end
    hold();
    bus_start();
    put_byte({DEV, 1'b0}, a); chk("R9", "address after restart ack", a, 1'b1);
    put_byte(8'h00, a);
    put_byte(8'h33, a);
    bus_stop();
    chk("R9", "wiper1 after restart", w1, 8'h33);
    chk("R9", "wiper2 unchanged by cut byte", w2, 8'h80);

    // R6 pin and register bit together
    bus_start();
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h20, a);
    bus_stop();
    chk("R6", "register shutdown", sd_o, 1'b1);
    shdn_n = 1'b0;
    bus_start();
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h00, a);
    bus_stop();
    chk("R6", "pin keeps shutdown after bit cleared", sd_o, 1'b1);
    chk("R6", "wiper1 kept in shutdown", w1, 8'h33);
    shdn_n = 1'b1;
    @(negedge clk);
    chk("R6", "shutdown released", sd_o, 1'b0);
    chk("R6", "wiper2 kept after release", w2, 8'h80);

    chk("R10", "drive changes with SCL high", viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule